// File: doc/BRIEF.md
# Video Memory Line Shifter

This block is the serial read side of a dual-ported video memory. When the random-access side issues a row transfer, the block captures one complete row of the array in a single clock. It then streams that row to the display output, one item for each shift-enable cycle, in ascending column order. Because the row is held as a snapshot, the random-access side can keep rewriting the array while the display line is still being streamed.

The block drives the row address straight to the array's read port and takes the whole row back as one wide word. The array is read combinationally, in the same cycle as the transfer request. There is no write path: the only data the block takes in is the row word. One transfer feeds one horizontal display line. After the last item of the line has been used, a line-done flag stays high until the next transfer.

Top module: `vram_line_shifter`

## Requirements
- R1: Out of reset, `sout` is zero and `line_done` is low.
- R2: `row_sel` equals `xfer_row` in the same cycle. A clock edge with `xfer_req` high loads all of `row_data` at once. From the next cycle, `sout` shows item 0, the bits `[IW-1:0]`, and `line_done` is low.
- R3: Item k of a row occupies bits `[k*IW +: IW]`. Each edge with `shift_en` high and no transfer moves `sout` from item k to item k+1.
- R4: An edge with neither `xfer_req` nor `shift_en` leaves `sout` and `line_done` unchanged.
- R5: The shift edge taken while item `ITEMS-1` is shown raises `line_done`, and `sout` keeps the last item. Later shifts change nothing until the next transfer.
- R6: A transfer in the middle of a line, or after a line is done, reloads the register, returns to item 0 and clears `line_done`. A transfer wins over a shift in the same cycle.
- R7: Changing the array contents after a transfer has no effect on the items streamed from the captured row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_req | input | 1 | Row transfer request |
| xfer_row | input | ROW_AW | Row to transfer |
| row_sel | output | ROW_AW | Row address to the array read port |
| row_data | input | ITEMS*IW | Whole row returned by the array |
| shift_en | input | 1 | Shift-clock enable; one item per high cycle |
| sout | output | IW | Serial display data |
| line_done | output | 1 | The last item of the line has been used |

## Verification
The bench builds the block with 8 items of 4 bits per row and 8 rows. This makes it possible to transfer every row and step through every item position of each. Item values come from a closed-form formula of row and column, and each row is overwritten right after its transfer. Mid-line reloads are tried at every position of one row, and a transfer coinciding with a shift is checked separately.

// File: rtl/vram_line_shifter.sv
module vram_line_shifter #(
  parameter int ITEMS  = 8,
  parameter int IW     = 4,
  parameter int ROW_AW = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                xfer_req,
  input  logic [ROW_AW-1:0]   xfer_row,
  output logic [ROW_AW-1:0]   row_sel,
  input  logic [ITEMS*IW-1:0] row_data,
  input  logic                shift_en,
  output logic [IW-1:0]       sout,
  output logic                line_done
);
  localparam int PW   = (ITEMS > 1) ? $clog2(ITEMS) : 1;
  localparam int LAST = ITEMS - 1;

  logic [ITEMS*IW-1:0] line_q;
  logic [PW-1:0]       pos_q;
  logic                done_q;
  logic                at_end;

  assign row_sel   = xfer_row;
  assign sout      = line_q[IW-1:0];
  assign line_done = done_q;
  assign at_end    = (pos_q == PW'(LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      pos_q  <= '0;
      done_q <= 1'b0;
    end else if (xfer_req) begin
      line_q <= row_data;
      pos_q  <= '0;
      done_q <= 1'b0;
    end else if (shift_en && !done_q) begin
      if (at_end) begin
        done_q <= 1'b1;
      end else begin
        line_q <= line_q >> IW;
        pos_q  <= pos_q + PW'(1);
      end
    end
  end

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |=> (sout == $past(row_data[IW-1:0])) && !line_done);

  a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_req && shift_en && !done_q && !at_end) |=> (pos_q == $past(pos_q) + PW'(1)));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_req && !shift_en) |=> ($stable(sout) && $stable(line_done)));

  a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (line_done && !xfer_req) |=> (line_done && $stable(sout)));

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |=> (pos_q == '0));
endmodule

// File: tb/vram_line_shifter_test.sv
module vram_line_shifter_test;
  localparam int ITEMS = 8, IW = 4, ROW_AW = 3, ROWS = 8;

  logic clk = 1'b0, rst_n = 1'b0, xfer_req = 1'b0, shift_en = 1'b0;
  logic [ROW_AW-1:0] xfer_row = '0, row_sel;
  logic [ITEMS*IW-1:0] row_data;
  logic [IW-1:0] sout;
  logic line_done;
  logic [ITEMS*IW-1:0] mem [ROWS];
  int tests = 0, fails = 0;

  always #2 clk = ~clk;
  assign row_data = mem[row_sel];

  vram_line_shifter #(.ITEMS(ITEMS), .IW(IW), .ROW_AW(ROW_AW)) uut (
    .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .xfer_row(xfer_row),
    .row_sel(row_sel), .row_data(row_data), .shift_en(shift_en),
    .sout(sout), .line_done(line_done));

  function automatic logic [IW-1:0] item(int r, int k);
    return IW'((r * 3 + k * 5 + 1) % 16);
  endfunction

  function automatic logic [ITEMS*IW-1:0] row_word(int r);
    logic [ITEMS*IW-1:0] w;
    for (int k = 0; k < ITEMS; k++) w[k*IW +: IW] = item(r, k);
    return w;
  endfunction

  task automatic chk(string req, logic [IW-1:0] exp_d, logic exp_done);
    tests++;
    if (sout !== exp_d || line_done !== exp_done) begin
      fails++;
      $display("FAIL %s: sout=%0h done=%0b expected sout=%0h done=%0b",
               req, sout, line_done, exp_d, exp_done);
    end
  endtask

  task automatic step(logic x, logic s, int r);
    xfer_req = x; shift_en = s; xfer_row = ROW_AW'(r);
    @(posedge clk); #1;
    xfer_req = 1'b0; shift_en = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int r = 0; r < ROWS; r++) mem[r] = row_word(r);
    #7;
    chk("R1", '0, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R2 R3 R5 R7: every row, every position
    for (int r = 0; r < ROWS; r++) begin
      xfer_row = ROW_AW'(r); #0.5;
      tests++;
      if (row_sel !== ROW_AW'(r)) begin
        fails++; $display("FAIL R2: row_sel=%0d expected %0d", row_sel, r);
      end
      step(1'b1, 1'b0, r);
      mem[r] = ~row_word(r);
      chk("R2", item(r, 0), 1'b0);
      for (int k = 1; k < ITEMS; k++) begin
        step(1'b0, 1'b1, r);
        chk("R3 R7", item(r, k), 1'b0);
      end
      step(1'b0, 1'b0, r);
      chk("R4", item(r, ITEMS-1), 1'b0);
      step(1'b0, 1'b1, r);
      chk("R5", item(r, ITEMS-1), 1'b1);
      step(1'b0, 1'b1, r);
      chk("R5 sticky", item(r, ITEMS-1), 1'b1);
      mem[r] = row_word(r);
    end

    // R6: reload from every position, including done
    for (int p = 0; p <= ITEMS; p++) begin
      step(1'b1, 1'b0, 2);
      for (int k = 0; k < p; k++) step(1'b0, 1'b1, 2);
      step(1'b1, 1'b0, 5);
      chk("R6 reload", item(5, 0), 1'b0);
      step(1'b0, 1'b1, 5);
      chk("R6 next", item(5, 1), 1'b0);
    end

    // R6: transfer wins over simultaneous shift
    step(1'b0, 1'b1, 0);
    step(1'b1, 1'b1, 6);
    chk("R6 priority", item(6, 0), 1'b0);

    // R4: idle cycles hold
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b0, 1);
      chk("R4 idle", item(6, 0), 1'b0);
    end

    // R1: reset mid-line
    step(1'b0, 1'b1, 0);
    rst_n = 1'b0; #1;
    chk("R1 reset", '0, 1'b0);
    rst_n = 1'b1;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule